// File: doc/BRIEF.md
# I2C Slave Address Recognizer with 7-bit and 10-bit Own Address

This block is the front end of an I2C target device. It watches the bus clock and data lines, brings them into the system clock domain, and finds the start, repeated start and stop conditions. After every start it takes in the header byte and compares it with an own address that is set by configuration. The own address is either a 7-bit address or a 10-bit address. In 10-bit mode it decodes the special header prefix and then a second byte that carries the low eight address bits.

Once addressed, it acknowledges by pulling SDA low through an open-drain enable. It then works as a byte pipe. A write transfer delivers each received byte on a valid/data pair. A read transfer asks the local logic for each byte with a request pulse and shifts that byte out MSB first. A full 10-bit match is kept across a repeated start. A master can therefore turn a 10-bit write into a read by resending only the header with the read bit set.

Top module: `i2c_tenbit_slave`

## Requirements
- R1: A start or repeated start (SDA falling while SCL is high) is recognised in any state, including in the middle of a byte and while addressed. The byte that follows is always taken as a fresh header.
- R2: In 7-bit mode (`cfg_ten_bit`=0), a header whose bits [7:1] equal `cfg_addr[6:0]` is acknowledged. Acknowledging means holding SDA low (`sda_drive_low`=1) during the ninth SCL clock. Header bit 0 is the direction: 0 selects write and 1 selects read.
- R3: In 7-bit mode, a header whose top five bits are 11110 is never acknowledged, even when `cfg_addr[6:0]` holds that value.
- R4: In 10-bit mode, a header laid out as 11110, `cfg_addr[9:8]`, then R/W=0 (bit 0) is acknowledged. Any other header gets no acknowledge, and the slave leaves SDA alone until the next start.
- R5: In 10-bit mode, the byte that follows an accepted write header is compared with `cfg_addr[7:0]`. It is acknowledged only on equality, which completes the 10-bit match. On a mismatch the slave does not acknowledge and ignores the bus until the next start.
- R6: In a write transfer that is addressed, each data byte is acknowledged and appears on `rx_data` with a single-cycle `rx_valid` pulse once its eighth SCL falling edge has been seen.
- R7: After a full 10-bit match, a repeated start followed by the header 11110, `cfg_addr[9:8]`, R/W=1 is acknowledged and starts a read. The low address byte is not resent. Without a prior full match, that read header is not acknowledged.
- R8: In a read, `tx_req` pulses once for every byte the slave is about to send. `tx_data` is captured at the SCL falling edge that ends the preceding acknowledge clock. The byte is sent MSB first, and SDA is pulled low only for 0 bits.
- R9: A low acknowledge from the master after a read byte makes the slave send the next byte. A high acknowledge makes it release SDA, issue no further `tx_req`, and stay silent until a stop or start.
- R10: A stop condition clears a recorded full 10-bit match. A start whose header is not accepted also clears it.
- R11: After reset, SDA is released and `rx_valid` and `tx_req` are low. The slave changes its SDA drive only while SCL is low, except when it releases on a start or stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as sensed at the pad |
| sda_in | input | 1 | Bus data line as sensed at the pad |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| cfg_ten_bit | input | 1 | Address mode: 1 selects 10-bit, 0 selects 7-bit |
| cfg_addr | input | 10 | Own address; only bits [6:0] count in 7-bit mode |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` holds a written byte |
| rx_data | output | 8 | Last byte received in a write transfer |
| tx_req | output | 1 | One-cycle pulse: supply the next read byte on `tx_data` |
| tx_data | input | 8 | Byte to send in a read transfer |

## Verification
The hardest state to reach from the ports is the kept 10-bit match. It exists only after a write header and a matching low byte. It has to survive a repeated start, and it has to be lost after a stop or after a repeated start with a foreign header. The bench builds each of these paths as a full bus sequence: write header, low byte, optional data, repeated start, read header. It then reads bytes, acknowledging the first and refusing the second. That shows both the `tx_req` count and the silence after the refusal. A partial byte cut short by a repeated start checks that the header framing restarts cleanly.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned HI_W     = 2;
  localparam int unsigned ADDR_W   = BYTE_W + HI_W;
  localparam int unsigned PREFIX_W = BYTE_W - 1 - HI_W;
  localparam int unsigned CNT_W    = $clog2(BYTE_W + 2) + 1;

  localparam logic [PREFIX_W-1:0] TEN_PREFIX = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_ADDR2,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } slv_state_e;

  typedef enum logic [1:0] {
    AFT_ADDR2,
    AFT_WDATA,
    AFT_RDATA
  } after_ack_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic [STAGES-1:0] scl_pipe_d, sda_pipe_d;
  logic scl_q, sda_q;

  assign scl_pipe_d = {scl_pipe[STAGES-2:0], scl_raw};
  assign sda_pipe_d = {sda_pipe[STAGES-2:0], sda_raw};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= scl_pipe_d;
      sda_pipe <= sda_pipe_d;
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  assert_edge_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |=> !scl_rise);
endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift
  import i2c_slv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              scl_rise,
  input  logic              sda_s,
  output logic [BYTE_W-1:0] byte_q,
  output logic [CNT_W-1:0]  bit_cnt
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [BYTE_W-1:0] byte_d;
  logic [CNT_W-1:0]  cnt_d;
  logic              upd_en;

  assign upd_en = clr | scl_rise;

  always_comb begin
    byte_d = byte_q;
    cnt_d  = bit_cnt;
    if (clr) begin
      cnt_d = '0;
    end else if (scl_rise) begin
      byte_d = {byte_q[BYTE_W-2:0], sda_s};
      if (bit_cnt != '1) cnt_d = bit_cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q  <= '0;
      bit_cnt <= '0;
    end else if (upd_en) begin
      byte_q  <= byte_d;
      bit_cnt <= cnt_d;
    end
  end

  assert_count_cleared_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> bit_cnt == '0);
endmodule

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp
  import i2c_slv_pkg::*;
(
  input  logic              ten_mode,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              hdr7_hit,
  output logic              hdr10_hit,
  output logic              low_hit,
  output logic              rw_bit
);
  timeunit 1ns;
  timeprecision 1ps;

  logic is_prefix;

  assign is_prefix = rx_byte[BYTE_W-1 -: PREFIX_W] == TEN_PREFIX;
  assign hdr7_hit  = !ten_mode && !is_prefix &&
                     (rx_byte[BYTE_W-1:1] == own_addr[BYTE_W-2:0]);
  assign hdr10_hit = ten_mode && is_prefix &&
                     (rx_byte[HI_W:1] == own_addr[ADDR_W-1:BYTE_W]);
  assign low_hit   = ten_mode && (rx_byte == own_addr[BYTE_W-1:0]);
  assign rw_bit    = rx_byte[0];
endmodule

// File: rtl/i2c_tenbit_slave.sv
module i2c_tenbit_slave
  import i2c_slv_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_drive_low,
  input  logic              cfg_ten_bit,
  input  logic [ADDR_W-1:0] cfg_addr,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic              tx_req,
  input  logic [BYTE_W-1:0] tx_data
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // bus sensing
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .scl_raw  (scl_in),
    .sda_raw  (sda_in),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  logic              shift_clr;
  logic [BYTE_W-1:0] rx_byte;
  logic [CNT_W-1:0]  bit_cnt;

  i2c_byte_shift u_shift (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (shift_clr),
    .scl_rise(scl_rise),
    .sda_s   (sda_s),
    .byte_q  (rx_byte),
    .bit_cnt (bit_cnt)
  );

  logic hdr7_hit, hdr10_hit, low_hit, rw_bit;

  i2c_addr_cmp u_cmp (
    .ten_mode (cfg_ten_bit),
    .own_addr (cfg_addr),
    .rx_byte  (rx_byte),
    .hdr7_hit (hdr7_hit),
    .hdr10_hit(hdr10_hit),
    .low_hit  (low_hit),
    .rw_bit   (rw_bit)
  );

  // control state
  slv_state_e        state_q, state_d;
  after_ack_e        after_q, after_d;
  logic              ten_hit_q, ten_hit_d;
  logic              drive_q, drive_d;
  logic              rx_valid_q, rx_valid_d;
  logic [BYTE_W-1:0] rx_data_q, rx_data_d;
  logic              tx_req_q, tx_req_d;
  logic [BYTE_W-1:0] tx_shift_q, tx_shift_d;
  logic              byte_done;

  assign byte_done = scl_fall && (bit_cnt == LAST_BIT);

  always_comb begin
    state_d    = state_q;
    after_d    = after_q;
    ten_hit_d  = ten_hit_q;
    drive_d    = drive_q;
    rx_valid_d = 1'b0;
    rx_data_d  = rx_data_q;
    tx_req_d   = 1'b0;
    tx_shift_d = tx_shift_q;
    shift_clr  = 1'b0;
    if (stop_det) begin
      state_d   = ST_IDLE;
      ten_hit_d = 1'b0;
      drive_d   = 1'b0;
      shift_clr = 1'b1;
    end else if (start_det) begin
      state_d   = ST_HDR;
      drive_d   = 1'b0;
      shift_clr = 1'b1;
    end else begin
      case (state_q)
        ST_HDR: begin
          if (byte_done) begin
            if (hdr7_hit) begin
              drive_d   = 1'b1;
              state_d   = ST_ACK;
              after_d   = rw_bit ? AFT_RDATA : AFT_WDATA;
              tx_req_d  = rw_bit;
              ten_hit_d = 1'b0;
            end else if (hdr10_hit && !rw_bit) begin
              drive_d   = 1'b1;
              state_d   = ST_ACK;
              after_d   = AFT_ADDR2;
              ten_hit_d = 1'b0;
            end else if (hdr10_hit && rw_bit && ten_hit_q) begin
              drive_d   = 1'b1;
              state_d   = ST_ACK;
              after_d   = AFT_RDATA;
              tx_req_d  = 1'b1;
            end else begin
              state_d   = ST_IDLE;
              ten_hit_d = 1'b0;
            end
          end
        end
        ST_ADDR2: begin
          if (byte_done) begin
            if (low_hit) begin
              drive_d   = 1'b1;
              state_d   = ST_ACK;
              after_d   = AFT_WDATA;
              ten_hit_d = 1'b1;
            end else begin
              state_d   = ST_IDLE;
            end
          end
        end
        ST_WDATA: begin
          if (byte_done) begin
            rx_valid_d = 1'b1;
            rx_data_d  = rx_byte;
            drive_d    = 1'b1;
            state_d    = ST_ACK;
            after_d    = AFT_WDATA;
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            shift_clr = 1'b1;
            if (after_q == AFT_RDATA) begin
              tx_shift_d = {tx_data[BYTE_W-2:0], 1'b0};
              drive_d    = ~tx_data[BYTE_W-1];
              state_d    = ST_RDATA;
            end else begin
              drive_d = 1'b0;
              state_d = (after_q == AFT_ADDR2) ? ST_ADDR2 : ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bit_cnt == LAST_BIT) begin
              drive_d = 1'b0;
              state_d = ST_RACK;
            end else begin
              drive_d    = ~tx_shift_q[BYTE_W-1];
              tx_shift_d = {tx_shift_q[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            if (sda_s) state_d = ST_IDLE;
            else       tx_req_d = 1'b1;
          end else if (scl_fall) begin
            shift_clr  = 1'b1;
            tx_shift_d = {tx_data[BYTE_W-2:0], 1'b0};
            drive_d    = ~tx_data[BYTE_W-1];
            state_d    = ST_RDATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q    <= ST_IDLE;
      after_q    <= AFT_WDATA;
      ten_hit_q  <= 1'b0;
      drive_q    <= 1'b0;
      rx_valid_q <= 1'b0;
      tx_req_q   <= 1'b0;
      tx_shift_q <= '0;
    end else begin
      state_q    <= state_d;
      after_q    <= after_d;
      ten_hit_q  <= ten_hit_d;
      drive_q    <= drive_d;
      rx_valid_q <= rx_valid_d;
      tx_req_q   <= tx_req_d;
      tx_shift_q <= tx_shift_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)     rx_data_q <= '0;
    else if (rx_valid_d) rx_data_q <= rx_data_d;
  end

  assign sda_drive_low = drive_q;
  assign rx_valid      = rx_valid_q;
  assign rx_data       = rx_data_q;
  assign tx_req        = tx_req_q;

  // checks on the control path
  assert_drive_on_low_scl_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(sda_drive_low) |-> !scl_s);

  assert_release_safe_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(sda_drive_low) |-> (!scl_s || $past(start_det || stop_det)));

  assert_match_needs_low_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(ten_hit_q) |-> ($past(state_q) == ST_ADDR2) && $past(low_hit));

  assert_reserved_no_ack_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_HDR && byte_done && !cfg_ten_bit &&
     rx_byte[BYTE_W-1 -: PREFIX_W] == TEN_PREFIX) |=> !sda_drive_low);

  assert_read_needs_match_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_HDR && byte_done && cfg_ten_bit && rx_byte[0] && !ten_hit_q)
      |=> state_q != ST_ACK);

  assert_rx_from_write_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_valid |-> $past(state_q) == ST_WDATA);

  assert_txreq_in_read_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_req |-> (state_q == ST_ACK || state_q == ST_RACK));
endmodule

// File: tb/test_i2c_tenbit_slave.sv
module test_i2c_tenbit_slave;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int Q = 8;           // SCL half period in system clocks
  localparam int NV = 10;

  typedef struct packed {
    logic       ten;
    logic [9:0] own;
    logic [7:0] b0;
    logic [7:0] b1;
    logic       ack0;
    logic       ack1;
    logic       rx;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 10'h052, 8'hA4, 8'h3C, 1'b1, 1'b1, 1'b1},
    '{1'b0, 10'h052, 8'hA6, 8'h3C, 1'b0, 1'b0, 1'b0},
    '{1'b0, 10'h07A, 8'hF4, 8'h11, 1'b0, 1'b0, 1'b0},
    '{1'b1, 10'h2C5, 8'hF4, 8'hC5, 1'b1, 1'b1, 1'b0},
    '{1'b1, 10'h2C5, 8'hF4, 8'hC4, 1'b1, 1'b0, 1'b0},
    '{1'b1, 10'h2C5, 8'hF2, 8'hC5, 1'b0, 1'b0, 1'b0},
    '{1'b1, 10'h2C5, 8'hF5, 8'hC5, 1'b0, 1'b0, 1'b0},
    '{1'b1, 10'h2C5, 8'hA4, 8'hC5, 1'b0, 1'b0, 1'b0},
    '{1'b0, 10'h013, 8'h26, 8'hFF, 1'b1, 1'b1, 1'b1},
    '{1'b1, 10'h1A3, 8'hF2, 8'hA3, 1'b1, 1'b1, 1'b0}
  };

  logic       clk;
  logic       rst_n;
  logic       scl_m, sda_m;
  logic       cfg_ten_bit;
  logic [9:0] cfg_addr;
  logic [7:0] tx_data;
  logic       sda_drive_low, rx_valid, tx_req;
  logic [7:0] rx_data;
  logic       sda_line;

  int n_chk = 0;
  int n_fail = 0;
  int rx_cnt = 0;
  int tx_cnt = 0;
  logic [7:0] rx_last = 8'h00;

  assign sda_line = sda_m & ~sda_drive_low;

  i2c_tenbit_slave i_i2c_tenbit_slave (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_in       (scl_m),
    .sda_in       (sda_line),
    .sda_drive_low(sda_drive_low),
    .cfg_ten_bit  (cfg_ten_bit),
    .cfg_addr     (cfg_addr),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .tx_req       (tx_req),
    .tx_data      (tx_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  always @(negedge clk) begin
    if (rx_valid) begin
      rx_cnt  = rx_cnt + 1;
      rx_last = rx_data;
    end
    if (tx_req) tx_cnt = tx_cnt + 1;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b1; wait_clk(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      wait_clk(Q/2); sda_m = b[i]; wait_clk(Q/2);
      scl_m = 1'b1; wait_clk(Q);
      scl_m = 1'b0;
    end
    wait_clk(Q/2); sda_m = 1'b1; wait_clk(Q/2);
    scl_m = 1'b1; wait_clk(Q/2);
    ack = ~sda_line;
    wait_clk(Q/2);
    scl_m = 1'b0;
  endtask

  task automatic read_byte(input logic m_ack, input logic [7:0] next_tx, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_clk(Q);
      scl_m = 1'b1; wait_clk(Q/2);
      b[i] = sda_line;
      wait_clk(Q/2);
      scl_m = 1'b0;
    end
    tx_data = next_tx;
    wait_clk(Q/2); sda_m = ~m_ack; wait_clk(Q/2);
    scl_m = 1'b1; wait_clk(Q);
    scl_m = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail + 1);
    $finish;
  end

  initial begin
    logic       ack;
    logic [7:0] rd;
    int         rx0, tx0;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    cfg_ten_bit = 1'b0; cfg_addr = 10'h052; tx_data = 8'h00;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(6);

    // R11 reset state
    check("R11 sda released", sda_drive_low, 1'b0);
    check("R11 rx_valid low", rx_valid, 1'b0);
    check("R11 tx_req low", tx_req, 1'b0);

    // vector table: header, second byte, stop
    for (int v = 0; v < NV; v++) begin
      cfg_ten_bit = VECS[v].ten;
      cfg_addr    = VECS[v].own;
      rx0 = rx_cnt;
      bus_start();
      send_byte(VECS[v].b0, ack);
      check($sformatf("vec %0d R2 R3 R4 header ack", v), ack, VECS[v].ack0);
      send_byte(VECS[v].b1, ack);
      check($sformatf("vec %0d R5 R6 second byte ack", v), ack, VECS[v].ack1);
      bus_stop();
      wait_clk(4);
      check($sformatf("vec %0d R6 rx count", v), rx_cnt - rx0, VECS[v].rx ? 1 : 0);
      if (VECS[v].rx) check($sformatf("vec %0d R6 rx data", v), rx_last, VECS[v].b1);
      check($sformatf("vec %0d R10 released after stop", v), sda_drive_low, 1'b0);
    end

    // 10-bit write then repeated-start read
    cfg_ten_bit = 1'b1; cfg_addr = 10'h2C5; tx_data = 8'hB6;
    bus_start();
    send_byte(8'hF4, ack); check("R4 write header", ack, 1'b1);
    send_byte(8'hC5, ack); check("R5 low byte", ack, 1'b1);
    send_byte(8'h5A, ack); check("R6 data ack", ack, 1'b1);
    wait_clk(2);
    check("R6 data value", rx_last, 8'h5A);
    tx0 = tx_cnt;
    bus_start();
    send_byte(8'hF5, ack); check("R7 read header after match", ack, 1'b1);
    read_byte(1'b1, 8'h3D, rd); check("R8 first read byte", rd, 8'hB6);
    read_byte(1'b0, 8'h00, rd); check("R8 second read byte", rd, 8'h3D);
    wait_clk(2);
    check("R9 released after nack", sda_drive_low, 1'b0);
    check("R9 tx_req count", tx_cnt - tx0, 2);
    read_byte(1'b0, 8'h00, rd); check("R9 silent after nack", rd, 8'hFF);
    check("R9 no further tx_req", tx_cnt - tx0, 2);
    bus_stop();

    // stop cleared the match
    bus_start();
    send_byte(8'hF5, ack); check("R10 read refused after stop", ack, 1'b0);
    bus_stop();

    // foreign header on repeated start clears the match
    bus_start();
    send_byte(8'hF4, ack); check("R4 header", ack, 1'b1);
    send_byte(8'hC5, ack); check("R5 low byte", ack, 1'b1);
    bus_start();
    send_byte(8'hF2, ack); check("R4 foreign header", ack, 1'b0);
    bus_start();
    send_byte(8'hF5, ack); check("R10 read refused after foreign header", ack, 1'b0);
    bus_stop();

    // 7-bit read with master nack
    cfg_ten_bit = 1'b0; cfg_addr = 10'h052; tx_data = 8'h81;
    tx0 = tx_cnt;
    bus_start();
    send_byte(8'hA5, ack); check("R2 read header", ack, 1'b1);
    read_byte(1'b0, 8'h00, rd); check("R8 7-bit read byte", rd, 8'h81);
    check("R8 single tx_req", tx_cnt - tx0, 1);
    bus_stop();

    // repeated start cutting a byte short, and while addressed
    bus_start();
    for (int i = 0; i < 3; i++) begin
      wait_clk(Q/2); sda_m = 1'b0; wait_clk(Q/2);
      scl_m = 1'b1; wait_clk(Q);
      scl_m = 1'b0;
    end
    bus_start();
    send_byte(8'hA4, ack); check("R1 header after cut byte", ack, 1'b1);
    send_byte(8'h12, ack); check("R1 data before restart", ack, 1'b1);
    bus_start();
    send_byte(8'hA4, ack); check("R1 header after restart", ack, 1'b1);
    bus_stop();
    wait_clk(4);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule